// File: doc/BRIEF.md
# Programmable Clocked One-Shot

This block turns a rising edge on a trigger line into a single output pulse whose length is a programmed number of clock cycles. Once the programmed time has run out the output drops back to its idle (low) level on its own, so low is the only state it stays in. All timing is counted in cycles of the block clock.

A run-time select chooses what happens when another trigger edge arrives while a pulse is running. In single-shot mode such an edge is dropped, except in the pulse's last cycle, where it chains a new pulse with no gap. In restart mode every edge reloads the full width. A trigger train faster than the width therefore holds the output high without a break. The width and the mode are read only in the cycle an edge is accepted, so a running pulse keeps the length it started with.

Top module: `oneshot_pulse`

## Requirements
- R1: While `rst` is high at a clock edge, `pulse_out` is low from the following cycle, the count is cleared and the previous trigger level is taken as low.
- R2: A rising edge on `trig_in` (high in this cycle, low in the cycle before), seen while idle with nonzero `width_in`, drives `pulse_out` high from the next cycle for exactly `width_in` cycles.
- R3: Holding `trig_in` high for many cycles counts as a single edge and does not start or extend a pulse.
- R4: With `retrig_en` = 0, an edge that arrives during a pulse before its last high cycle has no effect, and the pulse ends at its original time.
- R5: With `retrig_en` = 0, an edge in the last high cycle of a pulse starts a new pulse of `width_in` cycles with no low cycle in between.
- R6: With `retrig_en` = 1, an edge during a pulse restarts the count, so the output falls `width_in` cycles after the latest edge.
- R7: With `retrig_en` = 1, edges that come more often than the width keep `pulse_out` high in every cycle.
- R8: An edge seen while `width_in` is zero has no effect: it starts no pulse from idle and does not change a running pulse.
- R9: `width_in` and `retrig_en` are used only in the cycle an edge is accepted, so changing them during a pulse does not change that pulse.
- R10: Without an accepted edge, an idle output stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| trig_in | input | 1 | Trigger level; a low-to-high change is the trigger |
| width_in | input | WIDTH_BITS | Pulse length in clock cycles; 0 disables triggering |
| retrig_en | input | 1 | 1 = restart mode, 0 = single-shot mode |
| pulse_out | output | 1 | Registered pulse output, high while the pulse runs |

## Verification
The case that needs the most care is a trigger edge that lands in the same cycle a pulse is counting its last cycle. Here the end of one pulse and the start of the next fall together. The bench lets a single-shot pulse run down to its final high cycle and raises the trigger exactly then. It judges the result by requiring the output to stay high through the joint and then for a full new width. A second edge, one cycle earlier in the count, must leave the end time unchanged.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    // Behaviour chosen for an edge that arrives while a pulse is running
    typedef enum logic {
        MODE_SINGLE  = 1'b0,
        MODE_RESTART = 1'b1
    } oneshot_mode_e;

endpackage

// File: rtl/oneshot_edge.sv
module oneshot_edge (
    input  logic clk,
    input  logic rst,
    input  logic level_in,
    output logic rise_out
);

    logic prev_d, prev_q;

    always_comb begin
        prev_d   = level_in;
        rise_out = level_in & ~prev_q;
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= prev_d;
    end

endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
    import oneshot_pkg::*;
#(
    parameter int WIDTH_BITS = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  fire_in,
    input  logic [WIDTH_BITS-1:0] width_in,
    input  oneshot_mode_e         mode_in,
    output logic                  active_out
);

    localparam logic [WIDTH_BITS-1:0] ZERO = '0;
    localparam logic [WIDTH_BITS-1:0] ONE  = {{(WIDTH_BITS-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [WIDTH_BITS-1:0] remain;
        logic                  active;
    } timer_st_t;

    timer_st_t st_d, st_q;
    logic      may_load;
    logic      load;

    always_comb begin
        st_d = st_q;
        // single-shot accepts only when idle or in the final high cycle
        may_load = (st_q.remain <= ONE) || (mode_in == MODE_RESTART);
        load     = fire_in && (width_in != ZERO) && may_load;
        if (load)                    st_d.remain = width_in;
        else if (st_q.remain != ZERO) st_d.remain = st_q.remain - ONE;
        st_d.active = (st_d.remain != ZERO);
        active_out  = st_q.active;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

endmodule

// File: rtl/oneshot_pulse.sv
module oneshot_pulse
    import oneshot_pkg::*;
#(
    parameter int WIDTH_BITS = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  trig_in,
    input  logic [WIDTH_BITS-1:0] width_in,
    input  logic                  retrig_en,
    output logic                  pulse_out
);

    logic          rise;
    oneshot_mode_e mode;

    assign mode = retrig_en ? MODE_RESTART : MODE_SINGLE;

    oneshot_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .level_in (trig_in),
        .rise_out (rise)
    );

    oneshot_timer #(.WIDTH_BITS(WIDTH_BITS)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .fire_in    (rise),
        .width_in   (width_in),
        .mode_in    (mode),
        .active_out (pulse_out)
    );

endmodule

// File: rtl/oneshot_pulse_chk.sv
module oneshot_pulse_chk #(
    parameter int WIDTH_BITS = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  trig_in,
    input logic [WIDTH_BITS-1:0] width_in,
    input logic                  retrig_en,
    input logic                  pulse_out
);

    logic trig_seen_q;
    logic edge_c;

    always_ff @(posedge clk) begin
        if (rst) trig_seen_q <= 1'b0;
        else     trig_seen_q <= trig_in;
    end

    assign edge_c = trig_in && !trig_seen_q;

    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !pulse_out); // R1
    AST_IDLE_START: assert property (@(posedge clk) disable iff (rst)
        (!pulse_out && edge_c && width_in != '0) |=> pulse_out); // R2
    AST_LEVEL_NOSTART: assert property (@(posedge clk) disable iff (rst)
        (!pulse_out && trig_in && trig_seen_q) |=> !pulse_out); // R3
    AST_RESTART_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pulse_out && edge_c && retrig_en && width_in != '0) |=> pulse_out); // R6
    AST_ZERO_NOSTART: assert property (@(posedge clk) disable iff (rst)
        (!pulse_out && edge_c && width_in == '0) |=> !pulse_out); // R8
    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
        (!pulse_out && !edge_c) |=> !pulse_out); // R10

endmodule

bind oneshot_pulse oneshot_pulse_chk #(.WIDTH_BITS(WIDTH_BITS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .trig_in   (trig_in),
    .width_in  (width_in),
    .retrig_en (retrig_en),
    .pulse_out (pulse_out)
);

// File: tb/sim_oneshot_pulse.sv
module sim_oneshot_pulse;

    localparam int CLK_PERIOD = 10;
    localparam int WB = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          trig_in = 1'b0;
    logic [WB-1:0] width_in = '0;
    logic          retrig_en = 1'b0;
    logic          pulse_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    oneshot_pulse #(.WIDTH_BITS(WB)) u0 (
        .clk(clk), .rst(rst), .trig_in(trig_in),
        .width_in(width_in), .retrig_en(retrig_en), .pulse_out(pulse_out)
    );

    // vector: [10] trig, [9] restart mode, [8:1] width, [0] expected output next cycle
    localparam int NV = 21;
    localparam logic [10:0] VEC [NV] = '{
        {1'b0,1'b0,8'd3,1'b0},  // idle
        {1'b1,1'b0,8'd3,1'b1},  // R2 start
        {1'b1,1'b0,8'd3,1'b1},  // R3 held level
        {1'b0,1'b0,8'd3,1'b1},  // last high cycle next
        {1'b1,1'b0,8'd3,1'b1},  // R5 edge in last cycle chains
        {1'b0,1'b0,8'd3,1'b1},
        {1'b1,1'b0,8'd3,1'b1},  // R4 ignored mid-pulse
        {1'b0,1'b0,8'd3,1'b0},  // R4 ends on original time
        {1'b0,1'b0,8'd3,1'b0},
        {1'b1,1'b1,8'd4,1'b1},  // restart mode start
        {1'b0,1'b1,8'd4,1'b1},
        {1'b1,1'b1,8'd4,1'b1},  // R6 reload
        {1'b0,1'b1,8'd4,1'b1},
        {1'b0,1'b1,8'd4,1'b1},
        {1'b0,1'b1,8'd4,1'b1},
        {1'b0,1'b1,8'd4,1'b0},  // R6 ends 4 after latest edge
        {1'b1,1'b0,8'd0,1'b0},  // R8 zero width
        {1'b0,1'b0,8'd0,1'b0},
        {1'b1,1'b0,8'd2,1'b1},  // R9 width 2 captured
        {1'b0,1'b1,8'd7,1'b1},  // R9 change during pulse
        {1'b0,1'b1,8'd7,1'b0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD*200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        check(pulse_out == 1'b0, "R1 reset state", pulse_out, 0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            trig_in   = VEC[i][10];
            retrig_en = VEC[i][9];
            width_in  = VEC[i][8:1];
            @(negedge clk);
            check(pulse_out == VEC[i][0], $sformatf("vector %0d (R2-table)", i),
                  pulse_out, VEC[i][0]);
        end

        // R1: reset in the middle of a pulse
        trig_in = 1'b0; @(negedge clk);
        trig_in = 1'b1; width_in = 8'd5; retrig_en = 1'b0; @(negedge clk);
        rst = 1'b1; @(negedge clk);
        check(pulse_out == 1'b0, "R1 reset mid-pulse", pulse_out, 0);
        // R1: previous trigger level is low after reset, so a held high makes an edge
        rst = 1'b0; width_in = 8'd2; @(negedge clk);
        check(pulse_out == 1'b1, "R1 edge after reset release", pulse_out, 1);
        trig_in = 1'b0; @(negedge clk); @(negedge clk);
        check(pulse_out == 1'b0, "R1 post-reset pulse length", pulse_out, 0);

        // R2: maximum width, count high cycles
        begin
            int hi = 0;
            trig_in = 1'b1; width_in = 8'd255; @(negedge clk);
            trig_in = 1'b0;
            for (int c = 0; c < 300; c++) begin
                if (pulse_out) hi++;
                @(negedge clk);
            end
            check(hi == 255, "R2 width 255 length", hi, 255);
        end

        // R7: restart mode, edge every 17 cycles with width 20
        begin
            int lows = 0;
            int hi = 0;
            retrig_en = 1'b1; width_in = 8'd20;
            for (int p = 0; p < 6; p++) begin
                trig_in = 1'b1; @(negedge clk);
                trig_in = 1'b0;
                if (!pulse_out) lows++;
                for (int c = 0; c < 16; c++) begin
                    @(negedge clk);
                    if (!pulse_out) lows++;
                end
            end
            check(lows == 0, "R7 continuous high", lows, 0);
            // R6: after the last edge, total high = 20 cycles from that edge
            hi = 17;
            for (int c = 0; c < 10; c++) begin
                @(negedge clk);
                if (pulse_out) hi++;
            end
            check(hi == 20, "R6 fall after last edge", hi, 20);
        end

        // R8: zero-width edge during a running pulse leaves it unchanged
        begin
            int hi = 0;
            retrig_en = 1'b1; width_in = 8'd3; trig_in = 1'b1; @(negedge clk);
            trig_in = 1'b0; if (pulse_out) hi++; @(negedge clk);
            trig_in = 1'b1; width_in = 8'd0; if (pulse_out) hi++; @(negedge clk);
            trig_in = 1'b0;
            for (int c = 0; c < 6; c++) begin
                if (pulse_out) hi++;
                @(negedge clk);
            end
            check(hi == 3, "R8 running pulse unchanged", hi, 3);
        end

        // R10: idle output stays low with no edge
        begin
            int hi = 0;
            for (int c = 0; c < 20; c++) begin
                @(negedge clk);
                if (pulse_out) hi++;
            end
            check(hi == 0, "R10 idle stays low", hi, 0);
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule